// File: doc/BRIEF.md
# Power-Management Event Status and Enable Registers

This block holds two 16-bit registers for power-management events: a status register that records events as they happen, and an enable register that selects which recorded events may raise the system control interrupt (SCI). Together they fill a 4-byte window. Status takes byte offsets 0 and 1, and enable takes byte offsets 2 and 3. A bus master may read or write 1, 2 or 4 bytes starting at any byte offset.

Four single-cycle event inputs set status bits: timer overflow, global-lock release, power button and sleep button. Software clears a status bit by writing a one to it. The SCI output is a level. It stays high while any of the four event bits is both recorded and enabled. Interrupt routing, sleep control and address relocation are handled by other blocks.

Top module: `pwr_evt_regs`

## Requirements
- R1: After reset, status and enable read as zero and `sci` is low.
- R2: A pulse on `evTimer`, `evGlobal`, `evPwrBtn` or `evSlpBtn` sets status bit 0, 5, 8 or 9 respectively, and the bit reads as set after the next rising clock edge. The other status bits always read as zero.
- R3: A written byte that lands on offset 0 or 1 clears each status bit of that byte where the data holds a one, and leaves bits written as zero unchanged.
- R4: A written byte that lands on offset 2 or 3 replaces that byte of the enable register, and the other enable byte keeps its value.
- R5: `busSize` 0, 1 and 2 or 3 mean 1, 2 and 4 bytes. Data byte k (bits 8k+7:8k) goes to offset `busOffset`+k, so the lowest data byte goes to the lowest address.
- R6: During a read (`busValid`=1, `busWrite`=0), `busRdata` is {enable, status} shifted right by 8×`busOffset` bits. It is masked to 8 bits for a 1-byte read and to 16 bits for a 2-byte read. At all other times it is zero. The read has no effect on the registers.
- R7: Bytes that land on an offset of 4 or above change no register.
- R8: `sci` is high exactly when (enable AND status) has a one in bit 0, 5, 8 or 9. It follows a register change on the same edge that makes that change.
- R9: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busOffset | input | 3 | Starting byte offset |
| busSize | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| busWdata | input | 32 | Write data, lowest byte first |
| busRdata | output | 32 | Read data, combinational |
| evTimer | input | 1 | Timer overflow event pulse |
| evGlobal | input | 1 | Global-lock event pulse |
| evPwrBtn | input | 1 | Power button event pulse |
| evSlpBtn | input | 1 | Sleep button event pulse |
| sci | output | 1 | Level system control interrupt |

## Verification
Read data is combinational, so the bench checks it a moment after driving the address, inside the same cycle. Writes and event pulses are driven at a falling edge and take effect at the next rising edge. Register contents and `sci` are therefore read back and compared at the falling edge that follows that rising edge. A sweep covers every offset and size code for both writes and reads against an arithmetic model. Further directed sequences check each SCI mask bit and the case where an event and a clear arrive in the same cycle.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;
  localparam int BYTE_W    = 8;
  localparam int REG_W     = 16;
  localparam int REG_BYTES = REG_W / BYTE_W;
  localparam int WIN_BYTES = 2 * REG_BYTES;
  localparam int WORD_W    = WIN_BYTES * BYTE_W;

  localparam int BIT_TMR = 0;
  localparam int BIT_GLB = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_SLP = 9;

  localparam logic [REG_W-1:0] EVT_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_GLB) | (1 << BIT_PWR) | (1 << BIT_SLP));

  typedef struct packed {
    logic [REG_W-1:0]     stsClr;
    logic [REG_BYTES-1:0] enWe;
    logic [REG_W-1:0]     enData;
  } regStrobe_t;
endpackage

// File: rtl/pwr_evt_ctrl.sv
module pwr_evt_ctrl
  import pwr_evt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busOffset,
  input  logic [1:0]        busSize,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [REG_W-1:0]  stsQ,
  input  logic [REG_W-1:0]  enQ,
  output logic [WORD_W-1:0] busRdata,
  output regStrobe_t        stb
);
  localparam int WIDE_W = 2 * WORD_W * (1 << ADDR_W) / WIN_BYTES;

  logic [2:0]           nBytes;
  logic                 wrEn;
  logic [WIN_BYTES-1:0] laneHit;
  logic [BYTE_W-1:0]    laneByte [WIN_BYTES];
  logic [REG_W-1:0]     stsClrW;
  logic [REG_BYTES-1:0] enWeW;
  logic [REG_W-1:0]     enDataW;

  always_comb begin
    case (busSize)
      2'd0:    nBytes = 3'd1;
      2'd1:    nBytes = 3'd2;
      default: nBytes = 3'd4;
    endcase
  end

  assign wrEn = busValid && busWrite;

  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_lane
    int lane;
    assign lane        = g - int'(busOffset);
    assign laneHit[g]  = wrEn && (lane >= 0) && (lane < int'(nBytes));
    assign laneByte[g] = busWdata[BYTE_W*int'(lane[1:0]) +: BYTE_W];
    if (g < REG_BYTES) begin : g_sts
      assign stsClrW[BYTE_W*g +: BYTE_W] = laneHit[g] ? laneByte[g] : '0;
    end else begin : g_en
      assign enWeW[g-REG_BYTES]                        = laneHit[g];
      assign enDataW[BYTE_W*(g-REG_BYTES) +: BYTE_W]   = laneByte[g];
    end
  end

  always_comb begin
    stb.stsClr = stsClrW;
    stb.enWe   = enWeW;
    stb.enData = enDataW;
  end

  logic [WIDE_W-1:0] wide;
  logic [WORD_W-1:0] sizeMask;

  always_comb begin
    wide = {{(WIDE_W-WORD_W){1'b0}}, enQ, stsQ} >> ({3'b000, busOffset} * BYTE_W);
    case (busSize)
      2'd0:    sizeMask = WORD_W'(8'hFF);
      2'd1:    sizeMask = WORD_W'(16'hFFFF);
      default: sizeMask = '1;
    endcase
    busRdata = (busValid && !busWrite) ? (wide[WORD_W-1:0] & sizeMask) : '0;
  end

  AST_HIGH_OFS_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (busOffset >= ADDR_W'(WIN_BYTES)) |-> (stb.stsClr == '0 && stb.enWe == '0)); // R7
endmodule

// File: rtl/pwr_evt_dp.sv
module pwr_evt_dp
  import pwr_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  regStrobe_t       stb,
  input  logic             evTimer,
  input  logic             evGlobal,
  input  logic             evPwrBtn,
  input  logic             evSlpBtn,
  output logic [REG_W-1:0] stsQ,
  output logic [REG_W-1:0] enQ,
  output logic             sci
);
  logic [REG_W-1:0] evSet;
  logic [REG_W-1:0] stsD;
  logic [REG_W-1:0] enD;

  always_comb begin
    evSet          = '0;
    evSet[BIT_TMR] = evTimer;
    evSet[BIT_GLB] = evGlobal;
    evSet[BIT_PWR] = evPwrBtn;
    evSet[BIT_SLP] = evSlpBtn;
    stsD = ((stsQ & ~stb.stsClr) | evSet) & EVT_MASK;
  end

  for (genvar b = 0; b < REG_BYTES; b++) begin : g_en
    assign enD[BYTE_W*b +: BYTE_W] = stb.enWe[b] ? stb.enData[BYTE_W*b +: BYTE_W]
                                                 : enQ[BYTE_W*b +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stsQ <= '0;
      enQ  <= '0;
    end else begin
      stsQ <= stsD;
      enQ  <= enD;
    end
  end

  assign sci = |(stsQ & enQ & EVT_MASK);

  AST_PWR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evPwrBtn |=> stsQ[BIT_PWR]); // R2
  AST_SLP_ONLY_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stsQ[BIT_SLP]) |-> $past(evSlpBtn)); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.stsClr[BIT_PWR] && !evPwrBtn) |=> !stsQ[BIT_PWR]); // R3
  AST_EN_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.enWe[1] |=> $stable(enQ[15:8])); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evTimer && stb.stsClr[BIT_TMR]) |=> stsQ[BIT_TMR]); // R9
  AST_SCI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci) |-> $past(evTimer || evGlobal || evPwrBtn || evSlpBtn || (|stb.enWe))); // R8
endmodule

// File: rtl/pwr_evt_regs.sv
module pwr_evt_regs
  import pwr_evt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busOffset,
  input  logic [1:0]        busSize,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic              evTimer,
  input  logic              evGlobal,
  input  logic              evPwrBtn,
  input  logic              evSlpBtn,
  output logic              sci
);
  regStrobe_t       stb;
  logic [REG_W-1:0] stsQ;
  logic [REG_W-1:0] enQ;

  pwr_evt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .busValid(busValid), .busWrite(busWrite), .busOffset(busOffset),
    .busSize(busSize), .busWdata(busWdata),
    .stsQ(stsQ), .enQ(enQ), .busRdata(busRdata), .stb(stb)
  );

  pwr_evt_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .evTimer(evTimer), .evGlobal(evGlobal), .evPwrBtn(evPwrBtn), .evSlpBtn(evSlpBtn),
    .stsQ(stsQ), .enQ(enQ), .sci(sci)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!sci && stsQ == '0 && enQ == '0)); // R1
endmodule

// File: tb/pwr_evt_regs_bench.sv
`timescale 1ns/1ps
module pwr_evt_regs_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        busValid = 0, busWrite = 0;
  logic [2:0]  busOffset = 0;
  logic [1:0]  busSize = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic        evTimer = 0, evGlobal = 0, evPwrBtn = 0, evSlpBtn = 0;
  logic        sci;

  int nChecks = 0, nFails = 0;
  logic [15:0] mSts = 0, mEn = 0;
  localparam logic [15:0] MASK = 16'h0321;

  always #2 clk = ~clk;

  pwr_evt_regs u_pwr_evt_regs (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busOffset(busOffset), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .evTimer(evTimer), .evGlobal(evGlobal),
    .evPwrBtn(evPwrBtn), .evSlpBtn(evSlpBtn), .sci(sci)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int sizeBytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mRead(input int off, input int sz);
    logic [63:0] w;
    w = {32'b0, mEn, mSts} >> (8 * off);
    if (sz == 0) return w[31:0] & 32'hFF;
    if (sz == 1) return w[31:0] & 32'hFFFF;
    return w[31:0];
  endfunction

  task automatic mWrite(input int off, input int sz, input logic [31:0] d);
    for (int i = 0; i < sizeBytes(sz); i++) begin
      logic [7:0] b;
      b = d[8*i +: 8];
      case (off + i)
        0: mSts[7:0]  = mSts[7:0]  & ~b;
        1: mSts[15:8] = mSts[15:8] & ~b;
        2: mEn[7:0]   = b;
        3: mEn[15:8]  = b;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input int off, input int sz, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busOffset = 3'(off); busSize = 2'(sz); busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    mWrite(off, sz, d);
  endtask

  task automatic rd(input int off, input int sz, output logic [31:0] d);
    busValid = 1; busWrite = 0; busOffset = 3'(off); busSize = 2'(sz);
    #0.5;
    d = busRdata;
    busValid = 0;
    #0.5;
  endtask

  task automatic ev(input logic t, input logic g, input logic p, input logic s);
    @(negedge clk);
    evTimer = t; evGlobal = g; evPwrBtn = p; evSlpBtn = s;
    @(negedge clk);
    evTimer = 0; evGlobal = 0; evPwrBtn = 0; evSlpBtn = 0;
    mSts = mSts | ({6'b0, s, p, 2'b0, g, 4'b0, t} & MASK);
  endtask

  task automatic chkState(input string req);
    logic [31:0] d;
    rd(0, 2, d);
    chk(req, d, {mEn, mSts});
    chk({req, " R8 sci"}, 32'(sci), 32'(|(mEn & mSts & MASK)));
  endtask

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chkState("R1 reset");
    rd(0, 2, d);
    chk("R6 idle rdata zero", busRdata, 32'h0);

    // R2 each event sets its own bit
    ev(1, 0, 0, 0); chkState("R2 timer");
    ev(0, 1, 0, 0); chkState("R2 global");
    ev(0, 0, 1, 0); chkState("R2 power");
    ev(0, 0, 0, 1); chkState("R2 sleep");
    wr(0, 1, 32'hFFFF); chkState("R3 clear all");

    // R8 each mask bit alone drives sci
    for (int k = 0; k < 4; k++) begin
      int pos;
      logic [15:0] one;
      pos = (k == 0) ? 0 : (k == 1) ? 5 : (k == 2) ? 8 : 9;
      one = 16'(1 << pos);
      wr(2, 1, 32'(one));
      ev(1, 1, 1, 1);
      chkState("R8 sci on");
      wr(0, 1, 32'(one));
      chkState("R8 sci off after clear");
      wr(0, 1, 32'hFFFF);
    end

    // R3 R4 R5 R7 write sweep over all offsets and sizes
    for (int off = 0; off < 8; off++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic [31:0] pat;
        pat = 32'h9BC321FF;
        pat = (pat << ((off * 5 + sz) % 32)) | (pat >> ((32 - (off * 5 + sz)) % 32));
        wr(2, 1, 32'h5AC3);
        ev(1, 1, 1, 1);
        wr(off, sz, pat);
        chkState(off >= 4 ? "R7 high offset write" : "R3 R4 R5 write sweep");
      end
    end

    // R6 read sweep
    wr(0, 1, 32'hFFFF);
    ev(1, 0, 0, 1);
    wr(2, 1, 32'hA5C3);
    for (int off = 0; off < 8; off++) begin
      for (int sz = 0; sz < 4; sz++) begin
        rd(off, sz, d);
        chk("R6 read format", d, mRead(off, sz));
      end
    end
    chkState("R6 reads leave state");

    // R9 set wins over clear; sleep bit cleared alongside
    wr(0, 1, 32'hFFFF);
    ev(0, 0, 0, 1);
    @(negedge clk);
    busValid = 1; busWrite = 1; busOffset = 3'd1; busSize = 2'd0; busWdata = 32'h03;
    evPwrBtn = 1;
    @(negedge clk);
    busValid = 0; busWrite = 0; evPwrBtn = 0;
    mSts = 16'h0100;
    chkState("R9 set wins");

    // R1 reset again with state loaded
    ev(1, 1, 1, 1); wr(2, 1, 32'hFFFF);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    mSts = 0; mEn = 0;
    chkState("R1 reset clears");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule